// File: doc/BRIEF.md
# Stack Push Sequencer

This block turns one push request into the memory writes it needs. A request either stores one value (a general-purpose register, a sign-extended immediate or a segment selector) or stores all eight general-purpose registers. For each value the block lowers the stack pointer by the operand width and writes the value at the new top of stack. Writes leave through a simple write port that has a valid/ready handshake, one write per accepted cycle. When the last write has been accepted, the block reports the new stack pointer with a one-cycle completion pulse.

At the start strobe the block captures the stack pointer, the register-file snapshot and the immediate. Later changes on those inputs do not affect a push that is already running. When the request is illegal in 64-bit mode, the block performs no write and returns the completion pulse with an invalid-opcode flag. Segment limits, paging and alignment faults are handled elsewhere.

Top module: `stack_push_seq`

## Requirements
- R1: After reset, wrValid, done and badOp are low and spOut is zero.
- R2: A single push issues exactly one write, at address spIn minus the operand width in bytes. One cycle after that write is accepted, done is high and spOut holds that same address.
- R3: The operand width comes from sizeSel, reported in wrBytes as a byte count. Outside 64-bit mode, sizeSel 0 gives 2 bytes and sizeSel 1 or 2 gives 4 bytes. In 64-bit mode a single push always uses 8 bytes, whatever sizeSel is.
- R4: Write data is the selected value truncated to the operand width, with unused upper bits zero. With srcSel 0 the value is register regIdx of regFile (register k at bits 64k+63:64k). Index 4 names the stack pointer and stores spIn as it was at start. With srcSel 3 the value is segSel zero-extended.
- R5: With srcSel 1 the low 8 bits of immIn are sign-extended to the operand width. With srcSel 2 the 32-bit immIn is sign-extended to 64 bits and then truncated to the operand width.
- R6: When allRegs is set, eight writes go out at strictly descending addresses spaced by the operand width. They hold register indices 0, 1, 2, 3, original spIn, 5, 6, 7 in that order. spOut ends at spIn minus 8 times the width (16 bytes at 16-bit size, 32 bytes at 32-bit size).
- R7: In 64-bit mode, a push-all or a segment push (srcSel 3) issues no write. One cycle after start, done and badOp are high and spOut equals spIn.
- R8: While wrValid is high and wrReady is low, wrValid stays high and wrAddr, wrData and wrBytes hold their values.
- R9: done lasts exactly one cycle. A start strobe that arrives while a push is in progress is ignored.
- R10: spOut changes only in a cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when the block is idle |
| allRegs | input | 1 | 1: push all eight registers, 0: single push |
| srcSel | input | 2 | Single-push source: 0 register, 1 imm8, 2 imm32, 3 segment selector |
| regIdx | input | 3 | Register index for srcSel 0 |
| sizeSel | input | 2 | Operand size: 0 = 16, 1 = 32, 2 = 64 bits |
| longMode | input | 1 | 64-bit mode flag |
| spIn | input | 64 | Stack pointer before the push |
| regFile | input | 512 | Register snapshot, eight 64-bit registers |
| immIn | input | 32 | Immediate operand |
| segSel | input | 16 | Segment selector value |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Write port accepts the request |
| wrAddr | output | 64 | Write byte address |
| wrData | output | 64 | Write data, right-aligned |
| wrBytes | output | 4 | Write size in bytes (2, 4 or 8) |
| spOut | output | 64 | Updated stack pointer |
| done | output | 1 | One-cycle completion pulse |
| badOp | output | 1 | Invalid-opcode flag, valid with done |

## Verification
The first write is due on the port one cycle after start is sampled. Each later write is due one cycle after the previous write is accepted. done and the new stack pointer are due one cycle after the final acceptance, and for a rejected request one cycle after start. The bench samples at the falling edge. It compares each accepted write against a scoreboard queue filled by the driver's model, and it measures the latency to done in cycles for the rejected case and for the stall-free single push. Stalled cycles are compared against the values held from the previous cycle.

// File: rtl/stack_push_pkg.sv
package stack_push_pkg;
  localparam int NREG   = 8;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 64;
  localparam int SP_IDX = 4;

  localparam logic [1:0] SRC_REG = 2'd0;
  localparam logic [1:0] SRC_IMM8 = 2'd1;
  localparam logic [1:0] SRC_IMM32 = 2'd2;
  localparam logic [1:0] SRC_SEG = 2'd3;

  typedef struct packed {
    logic load;
    logic advance;
    logic finish;
    logic reject;
  } seqStrobeT;
endpackage

// File: rtl/stack_push_ctrl.sv
module stack_push_ctrl
  import stack_push_pkg::*;
#(
  parameter int NUM_REGS = NREG,
  localparam int CNT_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             allRegs,
  input  logic [1:0]       srcSel,
  input  logic             longMode,
  input  logic             wrReady,
  output logic             wrValid,
  output logic             done,
  output logic             badOp,
  output logic [CNT_W-1:0] slot,
  output seqStrobeT        strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_FIN} stateT;

  stateT state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic allQ;
  logic badQ;
  logic illegal;
  logic lastSlot;
  logic accept;

  assign illegal  = longMode && (allRegs || srcSel == SRC_SEG);
  assign wrValid  = (state == ST_BUSY);
  assign accept   = wrValid && wrReady;
  assign lastSlot = allQ ? (cnt == CNT_W'(NUM_REGS - 1)) : 1'b1;
  assign slot     = cnt;
  assign done     = (state == ST_FIN);
  assign badOp    = done && badQ;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (illegal) begin
            strobe.reject = 1'b1;
            stateNext = ST_FIN;
          end else begin
            strobe.load = 1'b1;
            stateNext = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (accept) begin
          if (lastSlot) begin
            strobe.finish = 1'b1;
            stateNext = ST_FIN;
          end else begin
            strobe.advance = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      allQ  <= 1'b0;
      badQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.load) begin
        cnt  <= '0;
        allQ <= allRegs;
        badQ <= 1'b0;
      end else if (strobe.advance) begin
        cnt <= cnt + 1'b1;
      end
      if (strobe.reject) badQ <= 1'b1;
    end
  end

  // R9: completion pulse never lasts two cycles
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: the invalid flag appears only with completion
  a_r7_bad_with_done: assert property (@(posedge clk) disable iff (!rstN)
    badOp |-> done);
  // R8: a stalled request stays valid
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrValid);
  // R7: no write request accompanies a completion
  a_r7_no_write_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrValid);
endmodule

// File: rtl/stack_push_dp.sv
module stack_push_dp
  import stack_push_pkg::*;
#(
  parameter int NUM_REGS = NREG,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int SP_SLOT = SP_IDX,
  localparam int CNT_W = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobeT             strobe,
  input  logic [CNT_W-1:0]      slot,
  input  logic                  wrValid,
  input  logic                  wrReady,
  input  logic                  done,
  input  logic                  allRegs,
  input  logic [1:0]            srcSel,
  input  logic [2:0]            regIdx,
  input  logic [1:0]            sizeSel,
  input  logic                  longMode,
  input  logic [AW-1:0]         spIn,
  input  logic [NUM_REGS*DW-1:0] regFile,
  input  logic [31:0]           immIn,
  input  logic [15:0]           segSel,
  output logic [AW-1:0]         wrAddr,
  output logic [DW-1:0]         wrData,
  output logic [3:0]            wrBytes,
  output logic [AW-1:0]         spOut
);
  logic [DW-1:0]    regsQ [NUM_REGS];
  logic [AW-1:0]    spOrig;
  logic [AW-1:0]    ptr;
  logic [AW-1:0]    spOutQ;
  logic [31:0]      immQ;
  logic [15:0]      segQ;
  logic [1:0]       srcQ;
  logic             allQ;
  logic [CNT_W-1:0] idxQ;
  logic [3:0]       sizeQ;
  logic [3:0]       sizeNew;
  logic [CNT_W-1:0] curIdx;
  logic [DW-1:0]    regVal;
  logic [DW-1:0]    rawVal;

  // operand width in bytes at the request
  always_comb begin
    if (longMode && !allRegs) sizeNew = 4'd8;
    else if (sizeSel == 2'd0)  sizeNew = 4'd2;
    else                       sizeNew = 4'd4;
  end

  function automatic logic [DW-1:0] fitWidth(input logic [DW-1:0] v,
                                             input logic [3:0] nb);
    logic [DW-1:0] m;
    case (nb)
      4'd2:    m = DW'({16{1'b1}});
      4'd4:    m = DW'({32{1'b1}});
      default: m = '1;
    endcase
    return v & m;
  endfunction

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_snap
      always_ff @(posedge clk) begin
        if (!rstN) regsQ[g] <= '0;
        else if (strobe.load) regsQ[g] <= regFile[g*DW +: DW];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spOrig <= '0;
      ptr    <= '0;
      spOutQ <= '0;
      immQ   <= '0;
      segQ   <= '0;
      srcQ   <= SRC_REG;
      allQ   <= 1'b0;
      idxQ   <= '0;
      sizeQ  <= 4'd2;
    end else begin
      if (strobe.load) begin
        spOrig <= spIn;
        ptr    <= spIn - AW'(sizeNew);
        immQ   <= immIn;
        segQ   <= segSel;
        srcQ   <= srcSel;
        allQ   <= allRegs;
        idxQ   <= CNT_W'(regIdx);
        sizeQ  <= sizeNew;
      end else if (strobe.advance) begin
        ptr <= ptr - AW'(sizeQ);
      end
      if (strobe.finish) spOutQ <= ptr;
      else if (strobe.reject) spOutQ <= spIn;
    end
  end

  assign curIdx = allQ ? slot : idxQ;
  assign regVal = (curIdx == CNT_W'(SP_SLOT)) ? DW'(spOrig) : regsQ[curIdx];

  always_comb begin
    if (allQ) begin
      rawVal = regVal;
    end else begin
      unique case (srcQ)
        SRC_REG:   rawVal = regVal;
        SRC_IMM8:  rawVal = {{(DW-8){immQ[7]}}, immQ[7:0]};
        SRC_IMM32: rawVal = {{(DW-32){immQ[31]}}, immQ};
        default:   rawVal = DW'(segQ);
      endcase
    end
  end

  assign wrData  = fitWidth(rawVal, sizeQ);
  assign wrAddr  = ptr;
  assign wrBytes = sizeQ;
  assign spOut   = spOutQ;

  // R8: payload held during a stall
  a_r8_stable_payload: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> ($stable(wrAddr) && $stable(wrData) && $stable(wrBytes)));
  // R6: consecutive writes of one push step down by the width
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |=> (!wrValid || wrAddr == $past(wrAddr) - AW'(wrBytes)));
  // R3: the width is a single power of two
  a_r3_one_size: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> ($countones(wrBytes) == 1 && wrBytes >= 4'd2));
  // R10: stack pointer result moves only at completion
  a_r10_sp_at_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spOut) |-> done);
endmodule

// File: rtl/stack_push_seq.sv
module stack_push_seq
  import stack_push_pkg::*;
#(
  parameter int NUM_REGS = NREG,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   allRegs,
  input  logic [1:0]             srcSel,
  input  logic [2:0]             regIdx,
  input  logic [1:0]             sizeSel,
  input  logic                   longMode,
  input  logic [AW-1:0]          spIn,
  input  logic [NUM_REGS*DW-1:0] regFile,
  input  logic [31:0]            immIn,
  input  logic [15:0]            segSel,
  output logic                   wrValid,
  input  logic                   wrReady,
  output logic [AW-1:0]          wrAddr,
  output logic [DW-1:0]          wrData,
  output logic [3:0]             wrBytes,
  output logic [AW-1:0]          spOut,
  output logic                   done,
  output logic                   badOp
);
  localparam int CNT_W = $clog2(NUM_REGS);

  seqStrobeT strobe;
  logic [CNT_W-1:0] slot;

  stack_push_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .allRegs(allRegs),
    .srcSel(srcSel), .longMode(longMode), .wrReady(wrReady),
    .wrValid(wrValid), .done(done), .badOp(badOp), .slot(slot),
    .strobe(strobe)
  );

  stack_push_dp #(.NUM_REGS(NUM_REGS), .DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(slot),
    .wrValid(wrValid), .wrReady(wrReady), .done(done),
    .allRegs(allRegs), .srcSel(srcSel), .regIdx(regIdx),
    .sizeSel(sizeSel), .longMode(longMode), .spIn(spIn),
    .regFile(regFile), .immIn(immIn), .segSel(segSel),
    .wrAddr(wrAddr), .wrData(wrData), .wrBytes(wrBytes), .spOut(spOut)
  );
endmodule

// File: tb/stack_push_seq_tb.sv
module stack_push_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic allRegs = 1'b0;
  logic [1:0] srcSel = 2'd0;
  logic [2:0] regIdx = 3'd0;
  logic [1:0] sizeSel = 2'd0;
  logic longMode = 1'b0;
  logic [63:0] spIn = '0;
  logic [511:0] regFile = '0;
  logic [31:0] immIn = '0;
  logic [15:0] segSel = '0;
  logic wrReady = 1'b1;
  logic wrValid, done, badOp;
  logic [63:0] wrAddr, wrData, spOut;
  logic [3:0] wrBytes;

  int checks = 0;
  int errors = 0;
  int writeCount = 0;
  int readyMode = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [63:0] qAddr[$];
  logic [63:0] qData[$];
  logic [3:0]  qBytes[$];
  logic stallPend = 1'b0;
  logic [63:0] holdAddr, holdData, prevSp;
  logic [3:0] holdBytes;

  always #2 clk = ~clk;

  stack_push_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .allRegs(allRegs), .srcSel(srcSel),
    .regIdx(regIdx), .sizeSel(sizeSel), .longMode(longMode), .spIn(spIn),
    .regFile(regFile), .immIn(immIn), .segSel(segSel), .wrValid(wrValid),
    .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData), .wrBytes(wrBytes),
    .spOut(spOut), .done(done), .badOp(badOp)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] fitW(input logic [63:0] v, input int nb);
    if (nb == 2) return {48'd0, v[15:0]};
    if (nb == 4) return {32'd0, v[31:0]};
    return v;
  endfunction

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wrReady = (readyMode == 0) ? 1'b1 : (lfsr[0] & lfsr[2]);
  end

  // monitor: compares accepted writes with the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (wrValid) begin
        if (stallPend) begin
          check(wrAddr == holdAddr && wrData == holdData && wrBytes == holdBytes,
                "R8 stall hold", wrAddr, holdAddr);
        end
        if (wrReady) begin
          stallPend = 1'b0;
          writeCount++;
          if (qAddr.size() == 0) begin
            check(1'b0, "R7 unexpected write", wrAddr, 64'd0);
          end else begin
            check(wrAddr == qAddr[0], "R2/R6 write address", wrAddr, qAddr[0]);
            check(wrData == qData[0], "R4/R5/R6 write data", wrData, qData[0]);
            check(wrBytes == qBytes[0], "R3 write bytes", 64'(wrBytes), 64'(qBytes[0]));
            void'(qAddr.pop_front());
            void'(qData.pop_front());
            void'(qBytes.pop_front());
          end
        end else begin
          stallPend = 1'b1;
          holdAddr = wrAddr;
          holdData = wrData;
          holdBytes = wrBytes;
        end
      end
      if (!done) check(spOut == prevSp, "R10 spOut held", spOut, prevSp);
      prevSp = spOut;
    end
  end

  // driver: builds expectation, issues the request, waits for completion
  task automatic runPush(input logic all, input logic [1:0] src, input logic [2:0] idx,
                         input logic [1:0] sz, input logic lm, input logic [63:0] sp,
                         input logic [31:0] imm, input logic [15:0] seg,
                         input int expLat, input logic spoil);
    int nb, n, lat, w0;
    logic bad;
    logic [63:0] a, v;
    bad = lm && (all || src == 2'd3);
    nb = (lm && !all) ? 8 : (sz == 2'd0 ? 2 : 4);
    n = bad ? 0 : (all ? 8 : 1);
    a = sp;
    for (int k = 0; k < n; k++) begin
      int r;
      r = all ? k : int'(idx);
      a = a - 64'(nb);
      if (all || src == 2'd0) v = (r == 4) ? sp : regFile[r*64 +: 64];
      else if (src == 2'd1) v = {{56{imm[7]}}, imm[7:0]};
      else if (src == 2'd2) v = {{32{imm[31]}}, imm};
      else v = {48'd0, seg};
      qAddr.push_back(a);
      qData.push_back(fitW(v, nb));
      qBytes.push_back(4'(nb));
    end
    w0 = writeCount;
    @(posedge clk); #1;
    allRegs = all; srcSel = src; regIdx = idx; sizeSel = sz; longMode = lm;
    spIn = sp; immIn = imm; segSel = seg; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (spoil) begin
      // R9: fresh inputs and a second start while busy
      spIn = ~sp; immIn = ~imm; regFile = ~regFile;
      repeat (2) @(posedge clk);
      #1 start = 1'b1; allRegs = 1'b0; srcSel = 2'd1;
      @(posedge clk); #1 start = 1'b0;
    end
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done);
    if (expLat > 0) check(lat == expLat, "R2/R7 done latency", 64'(lat), 64'(expLat));
    check(badOp == bad, "R7 badOp", 64'(badOp), 64'(bad));
    check(spOut == a, "R2/R6/R7 final spOut", spOut, a);
    check(qAddr.size() == 0, "R6 all writes seen", 64'(qAddr.size()), 64'd0);
    check(writeCount - w0 == n, "R7/R9 write count", 64'(writeCount - w0), 64'(n));
    @(negedge clk);
    check(!done, "R9 done one cycle", 64'(done), 64'd0);
    if (spoil) begin
      regFile = ~regFile;
      repeat (3) @(negedge clk);
      check(!wrValid && !done, "R9 start ignored when busy", 64'(wrValid), 64'd0);
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) regFile[r*64 +: 64] = 64'h8000_0000_0000_0000 | (64'h1111_2222_3333_0000 * (r + 1)) | 64'(r);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(!wrValid && !done && !badOp, "R1 reset outputs", {wrValid, done, badOp}, 0);
    check(spOut == 64'd0, "R1 reset spOut", spOut, 64'd0);
    rstN = 1'b1;
    prevSp = 64'd0;
    // R2 R3 R4 single register pushes, ready always high
    runPush(0, 2'd0, 3'd2, 2'd0, 0, 64'h0000_0000_0000_1000, 0, 0, 2, 0);
    runPush(0, 2'd0, 3'd7, 2'd1, 0, 64'h0000_0000_0000_2000, 0, 0, 2, 0);
    runPush(0, 2'd0, 3'd1, 2'd1, 1, 64'h0000_7FFF_0000_3000, 0, 0, 2, 0);
    runPush(0, 2'd0, 3'd3, 2'd2, 0, 64'h0000_0000_0000_2200, 0, 0, 2, 0);
    // R4 stack pointer index pushes original pointer
    runPush(0, 2'd0, 3'd4, 2'd0, 1, 64'h0000_0000_0000_4008, 0, 0, 2, 0);
    runPush(0, 2'd3, 3'd0, 2'd1, 0, 64'h0000_0000_0000_5000, 0, 16'hBEEF, 2, 0);
    // R5 immediates
    runPush(0, 2'd1, 3'd0, 2'd0, 0, 64'h0000_0000_0000_6000, 32'h0000_0085, 0, 2, 0);
    runPush(0, 2'd1, 3'd0, 2'd0, 1, 64'h0000_0000_0000_6000, 32'h1234_5680, 0, 2, 0);
    runPush(0, 2'd2, 3'd0, 2'd2, 1, 64'h0000_0000_0000_7000, 32'h8765_4321, 0, 2, 0);
    runPush(0, 2'd2, 3'd0, 2'd0, 0, 64'h0000_0000_0000_7000, 32'h8765_C321, 0, 2, 0);
    // R7 rejected requests in 64-bit mode
    runPush(1, 2'd0, 3'd0, 2'd1, 1, 64'h0000_0000_0000_8000, 0, 0, 1, 0);
    runPush(0, 2'd3, 3'd0, 2'd2, 1, 64'h0000_0000_0000_8100, 0, 16'h0010, 1, 0);
    // R6 R8 push-all with a stalling port, both sizes, with wrap
    readyMode = 1;
    runPush(1, 2'd0, 3'd0, 2'd0, 0, 64'h0000_0000_0000_9000, 0, 0, 0, 0);
    runPush(1, 2'd0, 3'd0, 2'd1, 0, 64'h0000_0000_0000_0010, 0, 0, 0, 0);
    runPush(0, 2'd0, 3'd5, 2'd1, 1, 64'h0000_0000_0000_A000, 0, 0, 0, 0);
    // R9 start while busy ignored
    runPush(1, 2'd0, 3'd0, 2'd1, 0, 64'h0000_0000_0000_B000, 0, 0, 0, 1);
    readyMode = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule